// File: doc/BRIEF.md
# Serial Control Receiver for a Stereo Volume and Balance Processor

This block is a write-only two-wire serial bus target. It accepts control settings for a two-input stereo volume and balance processor and turns them into decoded outputs for the analog path. It runs from a system clock that oversamples the bus. The clock and data lines are synchronised and glitch-filtered inside the block. An open-drain enable pulls the data line low for each acknowledge.

A transfer opens with START and the 7-bit device address with a write bit. Next comes a subaddress byte. It holds a 4-bit function index and a mode flag that picks between rewriting one setting and stepping through the settings in turn. Data bytes then land in an eight-entry bank of 8-bit settings that has defined reset values. Five of these entries drive outputs: the input selection, the input gain code, a volume attenuator with mute, and right and left speaker attenuators with mute. Each attenuator is given as a coarse step, a fine step and a mute flag.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: A START (data falling while clock is high) or STOP (data rising while clock is high) seen in any state abandons the current transfer. Bytes already acknowledged stay written, a partly received byte is dropped, and a STOP releases the data line.
- R2: Only the address byte 0x88 (7-bit address 1000100, write bit 0) is acknowledged. After any other address byte the block gives no acknowledge and writes nothing until the next START.
- R3: Bytes are 8 bits, MSB first. The block pulls data low during the ninth clock for every byte it accepts (address, subaddress, data), and only while the clock is low does it begin to pull.
- R4: In the subaddress byte, bits 3..0 are the function index and bit 4 is the step flag. Bits 7..5 have no effect.
- R5: With the step flag 0, every data byte up to STOP rewrites the same index.
- R6: With the step flag 1, the first data byte goes to the sent index and each later byte to the next index. Unused indices 3..5 still take a byte. Bytes for indices 8..15 are acknowledged but written nowhere. The index stops at 15.
- R7: Index 0 bits 1..0 pick the input: code 11 gives sel_in1=1, code 10 gives sel_in1=0. Codes 00 and 01 leave the selection unchanged.
- R8: Index 1 bits 3..0 appear on gain_code (2 dB per step, 0 to 30 dB).
- R9: Index 2 sets volume: bits 2..0 on vol_fine (1 dB steps), bits 5..3 on vol_coarse (8 dB steps). vol_mute is 1 exactly when bits 5..4 are both 1.
- R10: Index 6 sets the right speaker and index 7 the left: bits 2..0 fine, bits 6..3 coarse (8 dB steps, legal 0..9). Mute is 1 when the coarse code is above 9.
- R11: Reset gives sel_in1=0 (second input), gain_code=14 (28 dB), volume coarse 7 fine 0 muted, and both speakers coarse 15 fine 0 muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| sel_in1 | output | 1 | 1 selects the first stereo input, 0 the second |
| gain_code | output | 4 | Input gain code, 2 dB per step |
| vol_fine | output | 3 | Volume fine attenuation, 1 dB per step |
| vol_coarse | output | 3 | Volume coarse attenuation, 8 dB per step |
| vol_mute | output | 1 | Volume mute |
| spk_r_fine | output | 3 | Right speaker fine attenuation |
| spk_r_coarse | output | 4 | Right speaker coarse attenuation |
| spk_r_mute | output | 1 | Right speaker mute |
| spk_l_fine | output | 3 | Left speaker fine attenuation |
| spk_l_coarse | output | 4 | Left speaker coarse attenuation |
| spk_l_mute | output | 1 | Left speaker mute |

## Verification
Single-byte writes through a vector table cover each setting at legal, boundary and mute codes. Only the decoded fields move, and the disallowed select codes do not. Subaddresses with set upper bits show those bits are ignored. Multi-byte transfers with the step flag clear and set separate rewriting one index from stepping, and prove that unused slots take a byte and that indices past 7 and the index held at 15 write nothing. Wrong addresses, a read bit, a byte cut short by STOP or by a repeated START, and a mid-run reset check abort handling and the reset values.

// File: rtl/actl_pkg.sv
package actl_pkg;
  localparam int REG_W  = 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = 4;
  localparam logic [6:0] DEV_ADDR = 7'b1000100;

  localparam int IDX_INSEL = 0;
  localparam int IDX_GAIN  = 1;
  localparam int IDX_VOL   = 2;
  localparam int IDX_SPK_R = 6;
  localparam int IDX_SPK_L = 7;

  localparam logic [3:0] SPK_COARSE_MAX = 4'd9;

  typedef enum logic [2:0] {
    BS_IDLE, BS_RX, BS_ACK_WAIT, BS_ACK, BS_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    BK_ADDR, BK_SUB, BK_DATA
  } byte_kind_t;

  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      IDX_INSEL:            return 8'h02;
      IDX_GAIN:             return 8'h0E;
      IDX_VOL:              return 8'h38;
      IDX_SPK_R, IDX_SPK_L: return 8'h78;
      default:              return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/actl_line_filter.sv
module actl_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt,
  output logic rise,
  output logic fall
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt;
  logic                   prev;
  logic                   s_in;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign s_in = sync_q[SYNC_STAGES-1];

  // a new level is taken only after it has held for FILT_LEN samples
  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b1;
      prev <= 1'b1;
      cnt  <= '0;
    end else begin
      prev <= filt;
      if (s_in == filt) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
        filt <= s_in;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rise = filt & ~prev;
  assign fall = ~filt & prev;
endmodule

// File: rtl/actl_bus_engine.sv
module actl_bus_engine
  import actl_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda,
  input  logic          sda_rise,
  input  logic          sda_fall,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          stop_pulse,
  output logic          addr_hit
);
  localparam int BC_W = $clog2(DW);
  localparam logic [IW-1:0] IDX_LAST = '1;

  bus_state_t      st;
  byte_kind_t      kind;
  logic [BC_W-1:0] bit_cnt;
  logic [DW-1:0]   shreg;
  logic [DW-1:0]   byte_in;
  logic [IW-1:0]   idx;
  logic            auto_inc;
  logic            start_c;

  assign start_c    = sda_fall & scl;
  assign stop_pulse = sda_rise & scl;
  assign byte_in    = {shreg[DW-2:0], sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BS_IDLE;
      kind     <= BK_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      idx      <= '0;
      auto_inc <= 1'b0;
      sda_oe   <= 1'b0;
      addr_hit <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st       <= BS_RX;
        kind     <= BK_ADDR;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        addr_hit <= 1'b0;
      end else if (stop_pulse) begin
        st       <= BS_IDLE;
        sda_oe   <= 1'b0;
        addr_hit <= 1'b0;
      end else begin
        case (st)
          BS_RX: begin
            if (scl_rise) begin
              shreg   <= byte_in;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == BC_W'(DW - 1)) begin
                if (kind == BK_ADDR && byte_in != {DEV_ADDR, 1'b0})
                  st <= BS_IGNORE;
                else
                  st <= BS_ACK_WAIT;
              end
            end
          end
          BS_ACK_WAIT: begin
            if (scl_fall) begin
              sda_oe <= 1'b1;
              st     <= BS_ACK;
            end
          end
          BS_ACK: begin
            if (scl_rise) begin
              // the byte counts as taken once the acknowledge clock is high
              case (kind)
                BK_ADDR: begin
                  addr_hit <= 1'b1;
                  kind     <= BK_SUB;
                end
                BK_SUB: begin
                  idx      <= shreg[IW-1:0];
                  auto_inc <= shreg[4];
                  kind     <= BK_DATA;
                end
                default: begin
                  wr_en   <= ~idx[IW-1];
                  wr_idx  <= idx;
                  wr_data <= shreg;
                  if (auto_inc && idx != IDX_LAST) idx <= idx + 1'b1;
                end
              endcase
            end else if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              st      <= BS_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank
  import actl_pkg::*;
#(
  parameter int N  = NREG,
  parameter int DW = REG_W,
  parameter int IW = IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [N-1:0][DW-1:0] regs
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst)
        regs[i] <= reg_default(i);
      else if (wr_en && wr_idx == IW'(i))
        regs[i] <= wr_data;
    end
  end
endmodule

// File: rtl/actl_setting_decode.sv
module actl_setting_decode
  import actl_pkg::*;
#(
  parameter int N  = NREG,
  parameter int DW = REG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0][DW-1:0] regs,
  output logic                 sel_in1,
  output logic [3:0]           gain_code,
  output logic [2:0]           vol_fine,
  output logic [2:0]           vol_coarse,
  output logic                 vol_mute,
  output logic [2:0]           spk_r_fine,
  output logic [3:0]           spk_r_coarse,
  output logic                 spk_r_mute,
  output logic [2:0]           spk_l_fine,
  output logic [3:0]           spk_l_coarse,
  output logic                 spk_l_mute
);
  localparam logic [DW-1:0] D_SEL = reg_default(IDX_INSEL);
  localparam logic [DW-1:0] D_GN  = reg_default(IDX_GAIN);
  localparam logic [DW-1:0] D_VOL = reg_default(IDX_VOL);
  localparam logic [DW-1:0] D_R   = reg_default(IDX_SPK_R);
  localparam logic [DW-1:0] D_L   = reg_default(IDX_SPK_L);

  logic [DW-1:0] r_sel, r_gn, r_vol, r_r, r_l;
  logic          unused_bits;

  assign r_sel = regs[IDX_INSEL];
  assign r_gn  = regs[IDX_GAIN];
  assign r_vol = regs[IDX_VOL];
  assign r_r   = regs[IDX_SPK_R];
  assign r_l   = regs[IDX_SPK_L];
  assign unused_bits = ^{r_sel[DW-1:2], r_gn[DW-1:4], r_vol[DW-1:6],
                         r_r[DW-1], r_l[DW-1], regs[5:3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_in1      <= D_SEL[1:0] == 2'b11;
      gain_code    <= D_GN[3:0];
      vol_fine     <= D_VOL[2:0];
      vol_coarse   <= D_VOL[5:3];
      vol_mute     <= 1'b1;
      spk_r_fine   <= D_R[2:0];
      spk_r_coarse <= D_R[6:3];
      spk_r_mute   <= 1'b1;
      spk_l_fine   <= D_L[2:0];
      spk_l_coarse <= D_L[6:3];
      spk_l_mute   <= 1'b1;
    end else begin
      if (r_sel[1:0] == 2'b11)      sel_in1 <= 1'b1;
      else if (r_sel[1:0] == 2'b10) sel_in1 <= 1'b0;
      gain_code    <= r_gn[3:0];
      vol_fine     <= r_vol[2:0];
      vol_coarse   <= r_vol[5:3];
      vol_mute     <= r_vol[5] & r_vol[4];
      spk_r_fine   <= r_r[2:0];
      spk_r_coarse <= r_r[6:3];
      spk_r_mute   <= r_r[6:3] > SPK_COARSE_MAX;
      spk_l_fine   <= r_l[2:0];
      spk_l_coarse <= r_l[6:3];
      spk_l_mute   <= r_l[6:3] > SPK_COARSE_MAX;
    end
  end
endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
  import actl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       sel_in1,
  output logic [3:0] gain_code,
  output logic [2:0] vol_fine,
  output logic [2:0] vol_coarse,
  output logic       vol_mute,
  output logic [2:0] spk_r_fine,
  output logic [3:0] spk_r_coarse,
  output logic       spk_r_mute,
  output logic [2:0] spk_l_fine,
  output logic [3:0] spk_l_coarse,
  output logic       spk_l_mute
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] line_raw, line_f, line_r, line_fl;
  logic                        eng_wr_en;
  logic [IDX_W-1:0]            eng_wr_idx;
  logic [REG_W-1:0]            eng_wr_data;
  logic                        eng_stop;
  logic                        eng_addr_hit;
  logic [NREG-1:0][REG_W-1:0]  bank_regs;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    actl_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (line_raw[g]),
      .filt(line_f[g]),
      .rise(line_r[g]),
      .fall(line_fl[g])
    );
  end

  actl_bus_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl       (line_f[0]),
    .scl_rise  (line_r[0]),
    .scl_fall  (line_fl[0]),
    .sda       (line_f[1]),
    .sda_rise  (line_r[1]),
    .sda_fall  (line_fl[1]),
    .sda_oe    (sda_oe),
    .wr_en     (eng_wr_en),
    .wr_idx    (eng_wr_idx),
    .wr_data   (eng_wr_data),
    .stop_pulse(eng_stop),
    .addr_hit  (eng_addr_hit)
  );

  actl_reg_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (eng_wr_en),
    .wr_idx (eng_wr_idx),
    .wr_data(eng_wr_data),
    .regs   (bank_regs)
  );

  actl_setting_decode u_dec (
    .clk         (clk),
    .rst         (rst),
    .regs        (bank_regs),
    .sel_in1     (sel_in1),
    .gain_code   (gain_code),
    .vol_fine    (vol_fine),
    .vol_coarse  (vol_coarse),
    .vol_mute    (vol_mute),
    .spk_r_fine  (spk_r_fine),
    .spk_r_coarse(spk_r_coarse),
    .spk_r_mute  (spk_r_mute),
    .spk_l_fine  (spk_l_fine),
    .spk_l_coarse(spk_l_coarse),
    .spk_l_mute  (spk_l_mute)
  );
endmodule

// File: rtl/actl_checker.sv
module actl_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [3:0] wr_idx,
  input logic       stop_seen,
  input logic       addr_hit,
  input logic [1:0] sel_code,
  input logic       sel_in1,
  input logic [3:0] gain_code,
  input logic [2:0] vol_coarse,
  input logic       vol_mute,
  input logic       spk_r_mute,
  input logic       spk_l_mute
);
  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !sda_oe);

  assert_write_needs_addr_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> addr_hit);

  assert_ack_while_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_write_in_bank_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_idx < 4'd8);

  assert_sel_to_in1_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_in1) |-> $past(sel_code) == 2'b11);

  assert_sel_to_in2_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_in1) |-> $past(sel_code) == 2'b10);

  assert_gain_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && wr_idx == 4'd1, 2) |-> $stable(gain_code));

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sel_in1 && gain_code == 4'd14 && vol_coarse == 3'd7 &&
                    vol_mute && spk_r_mute && spk_l_mute));
endmodule

bind audio_ctrl_i2c_slave actl_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .wr_en     (eng_wr_en),
  .wr_idx    (eng_wr_idx),
  .stop_seen (eng_stop),
  .addr_hit  (eng_addr_hit),
  .sel_code  (bank_regs[0][1:0]),
  .sel_in1   (sel_in1),
  .gain_code (gain_code),
  .vol_coarse(vol_coarse),
  .vol_mute  (vol_mute),
  .spk_r_mute(spk_r_mute),
  .spk_l_mute(spk_l_mute)
);

// File: tb/audio_ctrl_i2c_slave_tb.sv
`timescale 1ns/1ps
module audio_ctrl_i2c_slave_tb;
  localparam int Q = 10;
  localparam int NV = 12;
  // {subaddress, data}
  localparam logic [15:0] VEC [NV] = '{
    16'h01_05, 16'h02_00, 16'h02_2B, 16'h02_30, 16'h06_4F, 16'h07_50,
    16'h00_03, 16'h00_01, 16'hE1_0F, 16'h07_12, 16'h00_02, 16'h0A_FF
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic scl_i, sda_i, sda_oe;
  logic sel_in1, vol_mute, spk_r_mute, spk_l_mute;
  logic [3:0] gain_code, spk_r_coarse, spk_l_coarse;
  logic [2:0] vol_fine, vol_coarse, spk_r_fine, spk_l_fine;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [8];
  logic       m_sel;

  always #2 clk = ~clk;

  assign scl_i = scl_m;
  assign sda_i = sda_m & ~sda_oe;

  audio_ctrl_i2c_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .sel_in1(sel_in1), .gain_code(gain_code), .vol_fine(vol_fine),
    .vol_coarse(vol_coarse), .vol_mute(vol_mute), .spk_r_fine(spk_r_fine),
    .spk_r_coarse(spk_r_coarse), .spk_r_mute(spk_r_mute),
    .spk_l_fine(spk_l_fine), .spk_l_coarse(spk_l_coarse),
    .spk_l_mute(spk_l_mute)
  );

  wire [27:0] dut_vec = {sel_in1, gain_code, vol_mute, vol_coarse, vol_fine,
                         spk_r_mute, spk_r_coarse, spk_r_fine,
                         spk_l_mute, spk_l_coarse, spk_l_fine};

  // R11 reset values; R7 selection state
  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    m_reg[0] = 8'h02; m_reg[1] = 8'h0E; m_reg[2] = 8'h38;
    m_reg[6] = 8'h78; m_reg[7] = 8'h78;
    m_sel = 1'b0;
  endtask

  task automatic model_write(input logic [3:0] idx, input logic [7:0] d);
    if (idx < 4'd8) begin
      m_reg[idx[2:0]] = d;
      if (idx == 4'd0) begin
        if (d[1:0] == 2'b11) m_sel = 1'b1;
        else if (d[1:0] == 2'b10) m_sel = 1'b0;
      end
    end
  endtask

  function automatic logic [27:0] expect_out();
    logic [7:0] v, r, l;
    v = m_reg[2]; r = m_reg[6]; l = m_reg[7];
    return {m_sel, m_reg[1][3:0], v[5] & v[4], v[5:3], v[2:0],
            r[6:3] > 4'd9, r[6:3], r[2:0], l[6:3] > 4'd9, l[6:3], l[2:0]};
  endfunction

  task automatic check(input string what, input logic [27:0] got,
                       input logic [27:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1; wait_clk(2 * Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    acked = ~sda_i;
    wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  // one transfer: address 0x88, subaddress, n data bytes
  task automatic write_seq(input logic [7:0] sub, input logic [7:0] d [8],
                           input int n, output logic all_ack);
    logic a;
    logic [3:0] idx;
    all_ack = 1'b1;
    idx = sub[3:0];
    bus_start();
    send_byte(8'h88, a); all_ack &= a;
    send_byte(sub, a);   all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); all_ack &= a;
      model_write(idx, d[i]);
      if (sub[4] && idx != 4'd15) idx = idx + 4'd1;
    end
    bus_stop();
    wait_clk(10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [8];
    logic ack, a2;
    model_reset();
    wait_clk(10);
    rst = 1'b0;
    wait_clk(5);
    check("R11 reset outputs", dut_vec, expect_out());
    check("R11 data released", {27'd0, sda_oe}, 28'd0);

    // table walk: single byte writes, step flag 0
    for (int v = 0; v < NV; v++) begin
      d[0] = VEC[v][7:0];
      write_seq(VEC[v][15:8], d, 1, ack);
      check($sformatf("R3 acks row %0d", v), {27'd0, ack}, 28'd1);
      check($sformatf("R4 R7 R8 R9 R10 decode row %0d", v), dut_vec, expect_out());
    end

    // R5: step flag clear, three bytes rewrite volume
    d[0] = 8'h05; d[1] = 8'h0C; d[2] = 8'h31;
    write_seq(8'h02, d, 3, ack);
    check("R5 same index rewrite", dut_vec, expect_out());
    check("R5 acks", {27'd0, ack}, 28'd1);

    // R6: stepping from volume through unused slots to speakers, then index 8
    d[0] = 8'h00; d[1] = 8'h0F; d[2] = 8'h0F; d[3] = 8'h0F;
    d[4] = 8'h02; d[5] = 8'h4A; d[6] = 8'h55;
    write_seq(8'h12, d, 7, ack);
    check("R6 stepping writes", dut_vec, expect_out());
    check("R6 acks incl index 8", {27'd0, ack}, 28'd1);

    // R6: start at 14, index held at 15, nothing written
    d[0] = 8'h00; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h00;
    write_seq(8'h1E, d, 4, ack);
    check("R6 saturated index writes nothing", dut_vec, expect_out());
    check("R6 saturated acks", {27'd0, ack}, 28'd1);

    // R2: wrong address and read bit give no ack, no write
    bus_start();
    send_byte(8'h8A, ack);
    send_byte(8'h01, a2);
    send_byte(8'h09, a2);
    bus_stop(); wait_clk(10);
    check("R2 wrong address nack", {27'd0, ack | a2}, 28'd0);
    check("R2 wrong address no write", dut_vec, expect_out());
    bus_start();
    send_byte(8'h89, ack);
    bus_stop(); wait_clk(10);
    check("R2 read bit nack", {27'd0, ack}, 28'd0);

    // R1: STOP in mid byte drops it
    bus_start();
    send_byte(8'h88, ack);
    send_byte(8'h01, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop(); wait_clk(10);
    check("R1 partial byte dropped on STOP", dut_vec, expect_out());
    check("R1 data released after STOP", {27'd0, sda_oe}, 28'd0);

    // R1: repeated START mid byte, earlier byte kept
    bus_start();
    send_byte(8'h88, ack);
    send_byte(8'h01, ack);
    send_byte(8'h03, ack);
    model_write(4'd1, 8'h03);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'h88, ack);
    send_byte(8'h06, ack);
    send_byte(8'h21, ack);
    model_write(4'd6, 8'h21);
    bus_stop(); wait_clk(10);
    check("R1 repeated START keeps acked, drops partial", dut_vec, expect_out());
    check("R1 ack after repeated START", {27'd0, ack}, 28'd1);

    // R11: reset in the middle of a run
    rst = 1'b1; wait_clk(3); rst = 1'b0;
    model_reset();
    wait_clk(3);
    check("R11 mid-run reset", dut_vec, expect_out());

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule